// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus (IEEE 802.3 clause 22). Software first writes the 5-bit address of the target PHY into a PHY-address register. It then writes one control word. That word carries a launch flag, the access direction, the PHY register number, write data, a clock-divider code and a preamble-skip option. The block produces the management clock (MDC) from its reference clock. It shifts the frame out on MDIO, releases the line for the PHY's reply on reads, and shifts the reply back in.

Completion is signalled through the control word itself. The launch flag and the busy flag both fall in the cycle the last data bit ends. After a read, the same word holds the 16 bits received from the PHY. While a frame runs, the control word is frozen: writes to it are dropped, so a frame cannot be disturbed midway.

The register side is a simple write strobe with a one-bit register select, plus a combinational read port. Select 0 is the control word and select 1 is the PHY-address register.

Top module: `mdio_mgmt_top`

## Requirements
- R1: After reset, `mdc` is 0, `mdioOe` is 0, and both registers read as all zeros.
- R2: Control word layout: bits 15:0 data, 20:16 PHY register number, 21 read (1) / write (0), 22 preamble skip, 23 launch, 26:24 clock code, 27 busy (read-only). Bits 31:27 ignore writes and bits 31:28 read 0. A write with bit 23 clear only updates the fields.
- R3: Writing bit 23 = 1 while idle sets launch and busy together. Both read 0 again exactly 2·H·N reference cycles after the write edge, where N is the frame length in bits.
- R4: A write frame is sent MSB first as: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, 16 data bits. N = 64 and `mdioOe` stays 1 for all of it.
- R5: With bit 22 set, the 32 leading ones are omitted and N = 32. The rest of the frame is unchanged.
- R6: A read frame uses opcode 10. `mdioOe` is 0 for the last 18 bit times (turnaround and data). `mdioIn` is sampled on rising `mdc`, MSB first. At completion, the 16 sampled bits appear in control bits 15:0.
- R7: Each MDC half-period lasts H = 2 + floor((12·code + 3)/7) reference cycles. Code 0 gives divide-by-4 and code 7 gives divide-by-28.
- R8: `mdioOut` changes only while `mdc` is low (at falling edges or at launch).
- R9: A control write while busy is ignored. The running frame, its length and all control fields are unaffected.
- R10: The PHY address is taken from bits 20:16 of register select 1, which reads back with all other bits 0.
- R11: Between frames, `mdc` stays low and `mdioOe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 control, 1 PHY address |
| wrData | input | 32 | Register write data |
| rdSel | input | 1 | Read target: 0 control, 1 PHY address |
| rdData | output | 32 | Combinational register read data |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data, driven value |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data, received value |

## Verification
A wrong bit counter or frame length shows up in the cycle at which busy drops. It moves by whole multiples of 2·H reference cycles, so it is visible at the end of the very frame it affects. A wrong divider code shows in the same count, and also in the MDC period seen by an attached PHY model. A fault in the shift or enable logic shows in the MDIO bit stream captured on rising MDC. There it corrupts the header within the first frame, or shifts the released window by whole bit times. A faulty receive path leaves the wrong value in bits 15:0 as soon as the read frame ends.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int SEL_W   = 3;
  localparam int PRE_LEN = 32;
  localparam int TA_W    = 2;
  localparam int CNT_W   = 4;
  localparam int FRAME_W = PRE_LEN + 2 + 2 + 2 * ADDR_W + TA_W + DATA_W;
  localparam int BITS_W  = $clog2(FRAME_W + 1);
  localparam int REL_LEN = TA_W + DATA_W;

  typedef struct packed {
    logic load;
    logic run;
    logic shift;
    logic sample;
    logic oe;
  } dpCmd_t;

  // reference cycles per MDC half period for a divider code
  function automatic logic [CNT_W-1:0] halfOf(input logic [SEL_W-1:0] code);
    int h;
    h = 2 + (12 * int'(code) + 3) / 7;
    return CNT_W'(h);
  endfunction
endpackage

// File: rtl/mdio_mgmt_dp.sv
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [FRAME_W-1:0] loadVec,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic               mdioIn,
  output logic               riseEv,
  output logic               fallEv,
  output logic               mdc,
  output logic               mdioOut,
  output logic               mdioOe,
  output logic [DATA_W-1:0]  rxData
);
  logic [CNT_W-1:0]   divCnt;
  logic [CNT_W-1:0]   halfLim;
  logic               mdcQ;
  logic               edgeNow;
  logic [FRAME_W-1:0] txSh;
  logic [DATA_W-1:0]  rxSh;

  assign halfLim = halfOf(clkSel);
  assign edgeNow = cmd.run && (divCnt == halfLim - CNT_W'(1));
  assign riseEv  = edgeNow && !mdcQ;
  assign fallEv  = edgeNow && mdcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      mdcQ   <= 1'b0;
    end else if (!cmd.run) begin
      divCnt <= '0;
      mdcQ   <= 1'b0;
    end else if (edgeNow) begin
      divCnt <= '0;
      mdcQ   <= ~mdcQ;
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
    end else if (cmd.load) begin
      txSh <= loadVec;
    end else if (cmd.shift) begin
      txSh <= {txSh[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0;
    end else if (cmd.sample) begin
      rxSh <= {rxSh[DATA_W-2:0], mdioIn};
    end
  end

  assign mdc     = mdcQ;
  assign mdioOut = txSh[FRAME_W-1];
  assign mdioOe  = cmd.oe;
  assign rxData  = rxSh;

  a_r8_out_on_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mdioOut) |-> !mdcQ);
  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |=> !mdcQ);
  a_r6_sample_released: assert property (@(posedge clk) disable iff (!rstN)
    cmd.sample |-> !cmd.oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [31:0]        wrData,
  input  logic               rdSel,
  output logic [31:0]        rdData,
  input  logic               riseEv,
  input  logic               fallEv,
  input  logic [DATA_W-1:0]  rxData,
  output dpCmd_t             cmd,
  output logic [FRAME_W-1:0] loadVec,
  output logic [SEL_W-1:0]   clkSel
);
  localparam int REG_LO = 16;
  localparam int RNW_B  = 21;
  localparam int SKIP_B = 22;
  localparam int GO_B   = 23;
  localparam int SEL_LO = 24;
  localparam int PHY_LO = 16;

  logic [DATA_W-1:0] dataF;
  logic [ADDR_W-1:0] regF;
  logic [ADDR_W-1:0] phyF;
  logic [SEL_W-1:0]  selF;
  logic              rnwF, skipF, startF, busyF;
  logic [BITS_W-1:0] bitsLeft;
  logic              ctrlWr, launch, lastBit;
  logic              wrRnw;
  logic [FRAME_W-1:0] frameVec;
  logic              unusedWrBits;

  assign unusedWrBits = &{1'b0, wrData[31:SEL_LO+SEL_W]};
  assign ctrlWr  = wrEn && !wrSel && !busyF;
  assign launch  = ctrlWr && wrData[GO_B];
  assign lastBit = busyF && fallEv && (bitsLeft == BITS_W'(1));
  assign wrRnw   = wrData[RNW_B];

  always_comb begin
    frameVec = {{PRE_LEN{1'b1}}, 2'b01,
                wrRnw ? 2'b10 : 2'b01,
                phyF,
                wrData[REG_LO +: ADDR_W],
                wrRnw ? 2'b11 : 2'b10,
                wrRnw ? {DATA_W{1'b1}} : wrData[DATA_W-1:0]};
    if (wrData[SKIP_B]) begin
      loadVec = {frameVec[FRAME_W-PRE_LEN-1:0], {PRE_LEN{1'b0}}};
    end else begin
      loadVec = frameVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyF <= '0;
    end else if (wrEn && wrSel) begin
      phyF <= wrData[PHY_LO +: ADDR_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataF    <= '0;
      regF     <= '0;
      selF     <= '0;
      rnwF     <= 1'b0;
      skipF    <= 1'b0;
      startF   <= 1'b0;
      busyF    <= 1'b0;
      bitsLeft <= '0;
    end else if (ctrlWr) begin
      dataF  <= wrData[DATA_W-1:0];
      regF   <= wrData[REG_LO +: ADDR_W];
      rnwF   <= wrData[RNW_B];
      skipF  <= wrData[SKIP_B];
      selF   <= wrData[SEL_LO +: SEL_W];
      startF <= wrData[GO_B];
      busyF  <= wrData[GO_B];
      bitsLeft <= wrData[SKIP_B] ? BITS_W'(FRAME_W - PRE_LEN) : BITS_W'(FRAME_W);
    end else if (busyF && fallEv) begin
      bitsLeft <= bitsLeft - BITS_W'(1);
      if (lastBit) begin
        startF <= 1'b0;
        busyF  <= 1'b0;
        if (rnwF) begin
          dataF <= rxData;
        end
      end
    end
  end

  always_comb begin
    cmd.load   = launch;
    cmd.run    = busyF;
    cmd.shift  = busyF && fallEv;
    cmd.sample = busyF && riseEv && rnwF && (bitsLeft <= BITS_W'(DATA_W));
    cmd.oe     = busyF && !(rnwF && (bitsLeft <= BITS_W'(REL_LEN)));
  end

  assign clkSel = selF;

  always_comb begin
    if (rdSel) begin
      rdData = {{(32-PHY_LO-ADDR_W){1'b0}}, phyF, {PHY_LO{1'b0}}};
    end else begin
      rdData = {4'b0, busyF, selF, startF, skipF, rnwF, regF, dataF};
    end
  end

  a_r9_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busyF && !fallEv && wrEn && !wrSel) |=>
      ($stable(regF) && $stable(selF) && $stable(rnwF) && $stable(skipF) && $stable(dataF)));
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rstN)
    busyF |-> (bitsLeft != '0) && (bitsLeft <= BITS_W'(FRAME_W)));
  a_r3_flags_together: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyF) |-> !startF && $past(bitsLeft) == BITS_W'(1));
endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [31:0] wrData,
  input  logic        rdSel,
  output logic [31:0] rdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  dpCmd_t             cmd;
  logic [FRAME_W-1:0] loadVec;
  logic [SEL_W-1:0]   clkSel;
  logic               riseEv, fallEv;
  logic [DATA_W-1:0]  rxData;

  mdio_mgmt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .riseEv(riseEv), .fallEv(fallEv),
    .rxData(rxData), .cmd(cmd), .loadVec(loadVec), .clkSel(clkSel)
  );

  mdio_mgmt_dp uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadVec(loadVec), .clkSel(clkSel),
    .mdioIn(mdioIn), .riseEv(riseEv), .fallEv(fallEv), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .rxData(rxData)
  );
endmodule

// File: tb/sim_mdio_mgmt_top.sv
module sim_mdio_mgmt_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {rnw, skip, code[2:0], phy[4:0], reg[4:0], data[15:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 3'd0, 5'h01, 5'h00, 16'hA5C3},
    {1'b1, 1'b0, 3'd0, 5'h1F, 5'h02, 16'h1234},
    {1'b0, 1'b1, 3'd0, 5'h0A, 5'h1F, 16'h8001},
    {1'b1, 1'b1, 3'd7, 5'h15, 5'h11, 16'hFFFE},
    {1'b0, 1'b0, 3'd3, 5'h00, 5'h0A, 16'h0000},
    {1'b1, 1'b0, 3'd1, 5'h11, 5'h04, 16'h8001}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0, rdSel = 1'b0, mdioIn = 1'b1;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic mdc, mdioOut, mdioOe;

  int total = 0, bad = 0;
  int fallCnt = 0, phyN = 64, capN = 0, glitch = 0;
  logic [15:0] phyData = '0;
  logic capEn = 1'b0;
  logic [63:0] capOut = '0, capOe = '0;
  logic prevOut = 1'b0;

  mdio_mgmt_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model: drives reply bits after falling MDC
  always @(negedge mdc) begin
    fallCnt = fallCnt + 1;
    if (fallCnt >= phyN - 16 && fallCnt < phyN)
      mdioIn = phyData[15 - (fallCnt - (phyN - 16))];
    else
      mdioIn = 1'b1;
  end

  always @(posedge mdc) begin
    if (capEn) begin
      capOut = {capOut[62:0], mdioOut};
      capOe  = {capOe[62:0], mdioOe};
      capN   = capN + 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && mdc === 1'b1 && mdioOut !== prevOut) glitch = glitch + 1;
    prevOut = mdioOut;
  end

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRd(input logic sel, output logic [31:0] d);
    rdSel = sel;
    #1;
    d = rdData;
  endtask

  function automatic int halfOfCode(input int code);
    return 2 + (12 * code + 3) / 7;
  endfunction

  // one frame; optional rejected control write after hitAt cycles
  task automatic runFrame(input logic [30:0] v, input int hitAt, input logic [31:0] hitVal,
                          input string tag);
    logic rnw, skip;
    logic [2:0] code;
    logic [4:0] phy, rg;
    logic [15:0] dat;
    logic [31:0] word, rb, expCtrl;
    logic [63:0] expFrame, expOe;
    int n, cyc, h;
    {rnw, skip, code, phy, rg, dat} = v;
    n = skip ? 32 : 64;
    h = halfOfCode(int'(code));
    regWr(1'b1, {11'b0, phy, 16'b0});
    regRd(1'b1, rb);
    check(rb == {11'b0, phy, 16'b0}, "R10 phy register readback", 64'(rb), 64'({11'b0, phy, 16'b0}));
    phyN = n; phyData = dat ^ 16'h5A5A; fallCnt = 0;
    capN = 0; capOut = '0; capOe = '0; capEn = 1'b1;
    word = {8'h00, 1'b1, skip, rnw, rg, dat};
    word[26:24] = code;
    @(negedge clk);
    wrEn = 1'b1; wrSel = 1'b0; wrData = word;
    @(negedge clk);
    wrEn = 1'b0;
    cyc = 0;
    regRd(1'b0, rb);
    while (rb[27] && cyc < 20000) begin
      if (cyc == hitAt) begin
        wrEn = 1'b1; wrSel = 1'b0; wrData = hitVal;
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk);
      cyc = cyc + 1;
      regRd(1'b0, rb);
    end
    wrEn = 1'b0;
    capEn = 1'b0;
    check(cyc == 2 * h * n, {tag, " R3 R7 frame duration"}, 64'(cyc), 64'(2 * h * n));
    check(capN == n, {tag, " R5 bit count"}, 64'(capN), 64'(n));
    expFrame = {32'hFFFF_FFFF, 2'b01, rnw ? 2'b10 : 2'b01, phy, rg, 2'b10, dat};
    if (skip) expFrame = {32'b0, expFrame[31:0]};
    expOe = skip ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_FFFF_FFFF;
    if (rnw) begin
      expOe = expOe & ~64'h3FFFF;
      check((capOut >> 18) == (expFrame >> 18), {tag, " R6 read header bits"}, capOut >> 18, expFrame >> 18);
      check(capOe == expOe, {tag, " R6 released window"}, capOe, expOe);
    end else begin
      check(capOut == expFrame, {tag, " R4 write frame bits"}, capOut, expFrame);
      check(capOe == expOe, {tag, " R4 driven whole frame"}, capOe, expOe);
    end
    expCtrl = {4'b0, 1'b0, code, 1'b0, skip, rnw, rg, rnw ? (dat ^ 16'h5A5A) : dat};
    regRd(1'b0, rb);
    check(rb == expCtrl, {tag, " R6 R2 control after completion"}, 64'(rb), 64'(expCtrl));
    repeat (3) @(negedge clk);
    check(mdc == 1'b0 && mdioOe == 1'b0, {tag, " R11 idle lines"}, 64'({mdc, mdioOe}), 64'(0));
  endtask

  initial begin
    logic [31:0] rb;
    repeat (3) @(negedge clk);
    regRd(1'b0, rb);
    check(rb == 32'h0 && mdc == 1'b0 && mdioOe == 1'b0, "R1 reset in reset", 64'({mdc, mdioOe, rb}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    regRd(1'b0, rb);
    check(rb == 32'h0, "R1 control after reset", 64'(rb), 64'(0));
    regRd(1'b1, rb);
    check(rb == 32'h0, "R1 phy register after reset", 64'(rb), 64'(0));
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 lines after reset", 64'({mdc, mdioOe}), 64'(0));

    // R2: field write without launch, upper bits ignored
    regWr(1'b0, 32'hF765_4321);
    regRd(1'b0, rb);
    check(rb == 32'h0765_4321, "R2 field write without launch", 64'(rb), 64'h0765_4321);
    repeat (20) @(negedge clk);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R11 no frame without launch", 64'({mdc, mdioOe}), 64'(0));

    for (int i = 0; i < NVEC; i++) begin
      runFrame(VEC[i], -1, 32'h0, $sformatf("vec%0d", i));
    end

    // R9: control write mid-frame must be dropped
    runFrame({1'b0, 1'b0, 3'd0, 5'h03, 5'h07, 16'hC0DE}, 40, 32'h07FF_FFFF, "R9 busy write");

    check(glitch == 0, "R8 mdio changed while mdc high", 64'(glitch), 64'(0));
    summary();
    $finish;
  end
endmodule